// File: doc/BRIEF.md
# Peak-Current-Mode PWM Switch Controller

This block is the digital decision logic of a peak-current-mode switching regulator. A free-running cycle counter sets the switching period. The power-switch gate turns on at the first count of every period. It turns off at the first of these events: the current comparator reports that the sensed switch current has crossed the error-amplifier level, the current-limit flag rises, or the count reaches the maximum on-time. Once the gate is off, it stays off until the next period begins, even if the cause of the turn-off goes away.

Two inputs override normal switching. A shutdown input and an overvoltage flag each pull the gate low and prevent any new turn-on while they are asserted. A separate select input chooses which of two feedback dividers the analog error amplifier uses. The block registers this choice and drives it out.

All asynchronous flags pass through a two-flop synchronizer before the logic uses them. A one-cycle pulse marks the start of each period, so that gate timing can be lined up against it.

Top module: `pwm_switch_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs settle to `gate_o`=0, `cyc_start_o`=0 and `fbsel_o`=1.
- R2: `cyc_start_o` is high for exactly one cycle out of every `PERIOD` cycles. The first pulse comes in the cycle after the first edge with reset released.
- R3: `gate_o` rises only in a cycle where `cyc_start_o` is high. It rises in every such cycle unless shutdown or overvoltage, as seen after synchronization, is asserted.
- R4: A high on `trip_i` clears `gate_o`. Counting the edge at which the input is first sampled high as the first edge, the gate is low after the third rising edge.
- R5: Once `gate_o` has fallen within a period, it stays low until the next `cyc_start_o`, whatever the inputs do.
- R6: A high on `ilim_i` clears `gate_o` with the same three-edge latency as R4, independent of `trip_i`.
- R7: `gate_o` is never high for more than MAX_ON consecutive cycles, where MAX_ON = floor(`PERIOD`*`DUTY_PCT`/100). With no trip, it is high for exactly MAX_ON cycles starting at `cyc_start_o`.
- R8: A high on `shdn_i` forces `gate_o` low from the second edge on, and blocks turn-on at cycle starts. After release, switching resumes at the next cycle start.
- R9: A high on `ovp_i` forces `gate_o` low from the second edge on, overriding every other input, and blocks turn-on while asserted.
- R10: `fbsel_o` follows `fb_sel_i` after two rising edges. 0 selects feedback input 1 and 1 selects feedback input 2. The reset value is 1, which matches an open pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_i | input | 1 | Current comparator: sensed current above error level (async) |
| ilim_i | input | 1 | Switch current-limit flag (async) |
| ovp_i | input | 1 | Input overvoltage flag (async) |
| shdn_i | input | 1 | Active-high switcher shutdown (async) |
| fb_sel_i | input | 1 | Feedback choice: 0 = input 1, 1 = input 2 (async) |
| gate_o | output | 1 | Power-switch gate drive |
| fbsel_o | output | 1 | Feedback multiplexer select |
| cyc_start_o | output | 1 | One-cycle pulse at the first count of each period |

## Verification
The bench applies comparator trips early and late in the on-window and then releases them mid-period. A design that retriggers would show a second gate pulse within the same period. A trip arriving after the duty cap, or no trip at all, must leave exactly MAX_ON high cycles; an off-by-one cap would show one extra or one missing cycle. Shutdown and overvoltage are asserted while the gate is on, across a cycle start, and released mid-period. A design that gated only at turn-on, or that restarted before the next period, would disagree with the reference model on that cycle.

// File: rtl/pwm_pkg.sv
// Package: shared flag bundle and derived constants for the PWM controller.
// Assumes the duty cap is given in whole percent.
package pwm_pkg;

    // Synchronized control flags, in the order the synchronizer carries them.
    typedef struct packed {
        logic fbsel;
        logic shdn;
        logic ovp;
        logic ilim;
        logic trip;
    } ctl_flags_t;

    localparam int unsigned FLAG_W = $bits(ctl_flags_t);

    // Maximum on-time in counts: period times duty percent, rounded down.
    function automatic int unsigned calc_max_on(input int unsigned period,
                                                input int unsigned pct);
        return (period * pct) / 100;
    endfunction

endpackage

// File: rtl/pwm_sync.sv
// Multi-bit, multi-stage synchronizer. Each bit is independent; no bus
// coherence is assumed. Each bit resets to its own value from RST_VAL.
module pwm_sync #(
    parameter int unsigned             WIDTH   = 5,
    parameter int unsigned             STAGES  = 2,
    parameter logic [WIDTH-1:0]        RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop captures the raw asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_next
                // Later flops let metastability resolve.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pwm_cycle_timer.sv
// Free-running period counter standing in for the timing-capacitor oscillator.
// The count runs 0..PERIOD-1. Reset loads PERIOD-1, so the first period
// begins on the first edge after reset is released. Assumes MAX_ON < PERIOD.
module pwm_cycle_timer #(
    parameter int unsigned PERIOD = 40,
    parameter int unsigned MAX_ON = 34,
    localparam int unsigned CW    = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt_o,
    output logic          start_o,
    output logic          last_o,
    output logic          cap_o
);

    localparam logic [CW-1:0] CNT_LAST = CW'(PERIOD - 1);
    localparam logic [CW-1:0] CNT_CAP  = CW'(MAX_ON - 1);

    logic [CW-1:0] cnt_q;

    // Advance the count and wrap at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= CNT_LAST;
        else if (cnt_q == CNT_LAST) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end

    // Decode period markers from the count.
    always_comb begin
        start_o = (cnt_q == '0) && rst_n;
        last_o  = (cnt_q == CNT_LAST);
        cap_o   = (cnt_q == CNT_CAP);
    end

    assign cnt_o = cnt_q;

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);

    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    assert_last_then_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> start_o);

endmodule

// File: rtl/pwm_gate_ctl.sv
// Gate state for one switching period. The gate is set at the period start
// unless shutdown or overvoltage is active. It is cleared by a comparator
// trip, the current limit, the duty cap, shutdown or overvoltage, and stays
// clear until the next start. Shutdown and overvoltage also mask the output
// at once. All flags are assumed already synchronized.
module pwm_gate_ctl #(
    parameter int unsigned PERIOD = 40,
    parameter int unsigned MAX_ON = 34,
    localparam int unsigned CW    = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          last_i,
    input  logic          cap_i,
    input  logic          start_i,
    input  logic          trip_i,
    input  logic          ilim_i,
    input  logic          ovp_i,
    input  logic          shdn_i,
    output logic          gate_o
);

    logic gate_q;
    logic block_w;
    logic stop_w;

    // Conditions that forbid turn-on and those that end the on-time.
    always_comb begin
        block_w = shdn_i | ovp_i;
        stop_w  = trip_i | ilim_i | cap_i | block_w;
    end

    // Set at the period wrap; clear once per period on any stop condition.
    always_ff @(posedge clk) begin
        if (!rst_n)          gate_q <= 1'b0;
        else if (last_i)     gate_q <= ~block_w;
        else if (stop_w)     gate_q <= 1'b0;
    end

    // Output mask: shutdown and overvoltage win at once.
    assign gate_o = gate_q & ~block_w;

    assert_rise_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q) |-> start_i);

    assert_no_retrigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_q && !last_i) |=> !gate_q);

    assert_trip_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_i && !last_i) |=> !gate_q);

    assert_limit_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim_i && !last_i) |=> !gate_q);

    assert_duty_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |-> (cnt_i < CW'(MAX_ON)));

    assert_ovp_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_i |=> !gate_q);

    assert_shdn_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_i |=> !gate_q);

endmodule

// File: rtl/pwm_switch_ctrl.sv
// Top level of the peak-current-mode PWM switch controller. It synchronizes
// the asynchronous flags, runs the period counter and the gate state, and
// drives the feedback select. Assumes 0 < DUTY_PCT < 100 and PERIOD >= 4.
module pwm_switch_ctrl #(
    parameter int unsigned PERIOD      = 40,
    parameter int unsigned DUTY_PCT    = 85,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic ilim_i,
    input  logic ovp_i,
    input  logic shdn_i,
    input  logic fb_sel_i,
    output logic gate_o,
    output logic fbsel_o,
    output logic cyc_start_o
);

    import pwm_pkg::*;

    localparam int unsigned MAX_ON = calc_max_on(PERIOD, DUTY_PCT);
    localparam int unsigned CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam ctl_flags_t  FLAG_RST = '{fbsel: 1'b1, default: 1'b0};

    ctl_flags_t    raw_w;
    ctl_flags_t    sync_w;
    logic [CW-1:0] cnt_w;
    logic          start_w;
    logic          last_w;
    logic          cap_w;

    // Bundle the raw asynchronous inputs.
    always_comb begin
        raw_w.fbsel = fb_sel_i;
        raw_w.shdn  = shdn_i;
        raw_w.ovp   = ovp_i;
        raw_w.ilim  = ilim_i;
        raw_w.trip  = trip_i;
    end

    pwm_sync #(
        .WIDTH   (FLAG_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (FLAG_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_w),
        .q_o   (sync_w)
    );

    pwm_cycle_timer #(
        .PERIOD (PERIOD),
        .MAX_ON (MAX_ON)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_o   (cnt_w),
        .start_o (start_w),
        .last_o  (last_w),
        .cap_o   (cap_w)
    );

    pwm_gate_ctl #(
        .PERIOD (PERIOD),
        .MAX_ON (MAX_ON)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (cnt_w),
        .last_i  (last_w),
        .cap_i   (cap_w),
        .start_i (start_w),
        .trip_i  (sync_w.trip),
        .ilim_i  (sync_w.ilim),
        .ovp_i   (sync_w.ovp),
        .shdn_i  (sync_w.shdn),
        .gate_o  (gate_o)
    );

    assign fbsel_o     = sync_w.fbsel;
    assign cyc_start_o = start_w;

    assert_fbsel_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(fbsel_o) |-> $past(fb_sel_i, 2) == fbsel_o);

endmodule

// File: tb/pwm_switch_ctrl_bench.sv
// Self-checking bench: a behavioural reference model is compared every clock,
// together with directed checks on timing windows.
module pwm_switch_ctrl_bench;

    localparam int PERIOD = 40;
    localparam int DUTY   = 85;
    localparam int MAXON  = (PERIOD * DUTY) / 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trip_i = 1'b0, ilim_i = 1'b0, ovp_i = 1'b0, shdn_i = 1'b0, fb_sel_i = 1'b1;
    logic gate_o, fbsel_o, cyc_start_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    bit    model_on = 0;
    bit    done     = 0;
    string phase    = "R1";

    pwm_switch_ctrl #(.PERIOD(PERIOD), .DUTY_PCT(DUTY)) u_pwm_switch_ctrl (
        .clk(clk), .rst_n(rst_n), .trip_i(trip_i), .ilim_i(ilim_i),
        .ovp_i(ovp_i), .shdn_i(shdn_i), .fb_sel_i(fb_sel_i),
        .gate_o(gate_o), .fbsel_o(fbsel_o), .cyc_start_o(cyc_start_o));

    always #10 clk = ~clk;

    // Reference model state: input histories as queues, period position, on flag.
    bit q_trip[$], q_ilim[$], q_ovp[$], q_shdn[$], q_sel[$];
    int m_pos;
    bit m_on, e_gate, e_start, e_sel;

    function automatic bit oldest(ref bit q[$], input bit rv);
        return (q.size() >= 2) ? q[0] : rv;
    endfunction

    task automatic push(ref bit q[$], input bit v);
        q.push_back(v);
        if (q.size() > 2) void'(q.pop_front());
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            q_trip.delete(); q_ilim.delete(); q_ovp.delete(); q_shdn.delete(); q_sel.delete();
            m_pos = PERIOD - 1; m_on = 0; model_on = 1;
            e_gate = 0; e_start = 0; e_sel = 1;
        end else begin
            bit f_trip, f_ilim, f_ovp, f_shdn;
            f_trip = oldest(q_trip, 0); f_ilim = oldest(q_ilim, 0);
            f_ovp  = oldest(q_ovp, 0);  f_shdn = oldest(q_shdn, 0);
            if (m_pos == PERIOD - 1) begin
                m_pos = 0;
                m_on  = !(f_ovp || f_shdn);
            end else begin
                if (f_trip || f_ilim || f_ovp || f_shdn || m_pos == MAXON - 1) m_on = 0;
                m_pos++;
            end
            push(q_trip, trip_i); push(q_ilim, ilim_i); push(q_ovp, ovp_i);
            push(q_shdn, shdn_i); push(q_sel, fb_sel_i);
            e_gate  = m_on && !oldest(q_ovp, 0) && !oldest(q_shdn, 0);
            e_start = (m_pos == 0);
            e_sel   = oldest(q_sel, 1);
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (model_on && !done) begin
            check(phase, gate_o, e_gate, "gate_o vs model");
            check(phase, cyc_start_o, e_start, "cyc_start_o vs model");
            check("R10", fbsel_o, e_sel, "fbsel_o vs model");
        end
    end

    task automatic wait_start();
        do @(negedge clk); while (!cyc_start_o);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        int run;
        bit stayed;
        idle(4);
        // R1: reset state
        check("R1", gate_o, 1'b0, "gate in reset");
        check("R1", cyc_start_o, 1'b0, "cyc_start in reset");
        check("R1", fbsel_o, 1'b1, "fbsel in reset");
        rst_n = 1'b1;

        // R2/R7: free run with no trip
        phase = "R7";
        wait_start();
        check("R3", gate_o, 1'b1, "gate high at cycle start");
        run = 0;
        while (gate_o) begin run++; @(negedge clk); end
        check_int("R7", run, MAXON, "on-time at duty cap");
        run = MAXON;
        while (!cyc_start_o) begin run++; @(negedge clk); end
        check_int("R2", run, PERIOD, "period length");

        // R4/R5: comparator trip at several offsets, released mid-period
        phase = "R4";
        for (int k = 2; k < 30; k += 9) begin
            wait_start();
            idle(k);
            trip_i = 1'b1;
            idle(2);
            check("R4", gate_o, 1'b1, "gate before trip latency");
            idle(1);
            check("R4", gate_o, 1'b0, "gate after trip latency");
            idle(2);
            trip_i = 1'b0;
            phase = "R5";
            stayed = 1;
            while (!cyc_start_o) begin
                if (gate_o) stayed = 0;
                @(negedge clk);
            end
            check("R5", stayed, 1'b1, "no retrigger in period");
            phase = "R4";
        end

        // R6: current limit alone
        phase = "R6";
        wait_start();
        idle(10);
        ilim_i = 1'b1;
        idle(3);
        check("R6", gate_o, 1'b0, "limit clears gate");
        idle(3);
        ilim_i = 1'b0;

        // R8: shutdown mid-on, across a cycle start, release mid-period
        phase = "R8";
        wait_start();
        idle(5);
        shdn_i = 1'b1;
        idle(1);
        check("R8", gate_o, 1'b1, "gate before shdn sync");
        idle(1);
        check("R8", gate_o, 1'b0, "shdn forces gate low");
        wait_start();
        check("R8", gate_o, 1'b0, "no turn-on in shdn");
        idle(8);
        shdn_i = 1'b0;
        idle(4);
        check("R8", gate_o, 1'b0, "stay off until next start");
        wait_start();
        check("R8", gate_o, 1'b1, "resume at next start");

        // R9: overvoltage overrides, even with trips absent
        phase = "R9";
        idle(3);
        ovp_i = 1'b1;
        idle(2);
        check("R9", gate_o, 1'b0, "ovp forces gate low");
        wait_start();
        check("R9", gate_o, 1'b0, "no turn-on in ovp");
        ovp_i = 1'b0;
        wait_start();
        check("R9", gate_o, 1'b1, "resume after ovp");

        // R10: feedback select
        phase = "R10";
        fb_sel_i = 1'b0;
        idle(1);
        check("R10", fbsel_o, 1'b1, "select before latency");
        idle(1);
        check("R10", fbsel_o, 1'b0, "select input 1");
        fb_sel_i = 1'b1;
        idle(2);
        check("R10", fbsel_o, 1'b1, "select input 2");

        phase = "R3";
        idle(2 * PERIOD);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule